// File: doc/BRIEF.md
# Pause Frame Transmit Flow Controller

This block decides when a full-duplex Ethernet MAC sends IEEE 802.3x PAUSE control frames. In half-duplex mode it drives back-pressure instead. The receive FIFO layer raises a flow-control request when it is filling up. The block then asks the frame transmitter for a PAUSE frame carrying the configured pause time, and holds that ask until the transmitter acknowledges it.

After each acknowledged frame, a slot-time counter is loaded with the pause time and counts down on every slot tick. One slot is 512 bit times. When the remaining time falls to a selectable margin, and the request is still high, the block asks for another frame. When the request is released after a frame has gone out, the block sends a frame with pause time zero so the link partner resumes at once, unless that behaviour is disabled.

The configured pause time enters the MAC clock domain through a multi-stage synchronizer. Software must therefore space its writes to that field by at least four MAC clock cycles.

Top module: `pause_tx_ctrl`

## Requirements
- R1: While reset is asserted and just after it is released, `pause_req` and `back_pressure` are low and `pause_value` is zero.
- R2: With `cfg_enable` high and `cfg_full_duplex` high, a high `fc_request` in the idle state raises `pause_req` one clock later, with `pause_value` equal to the synchronized pause time.
- R3: Once raised, `pause_req` stays high and `pause_value` stays unchanged until a cycle in which `pause_ack` is high.
- R4: The acknowledge of a non-zero frame loads the pause counter with the pause time, and each `slot_tick` decrements it. While `fc_request` is still high, a new frame is requested one clock after the counter reaches the margin chosen by `cfg_low_thr`: 4, 28, 144 or 256 slots for codes 0, 1, 2 and 3. For example, a pause time of 256 with code 1 re-sends after 228 ticks.
- R5: When the margin is not smaller than the pause time, a new frame is requested one clock after the acknowledge, with no tick needed.
- R6: If `fc_request` is low while a frame has been sent and its counter is running, and `cfg_zq_disable` is low, a frame with `pause_value` 0 is requested one clock later.
- R7: With `cfg_zq_disable` high, releasing `fc_request` requests no frame, and the block returns to idle.
- R8: With `cfg_full_duplex` high and `cfg_enable` low, `pause_req` never rises.
- R9: With `cfg_full_duplex` low and `cfg_enable` high, `back_pressure` equals `fc_request` in the same cycle and no PAUSE frame is requested. `back_pressure` is low whenever `cfg_full_duplex` is high or `cfg_enable` is low.
- R10: Without `slot_tick`, the pause counter holds its value, so no re-send occurs however many clocks pass.
- R11: `cfg_pause_time` passes through SYNC_STAGES flops (default 2). A frame requested in the clock edge right after the value changes still carries the previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | MAC transmit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | Flow control enable (PAUSE in full duplex, back-pressure in half duplex) |
| cfg_full_duplex | input | 1 | 1 = full duplex, 0 = half duplex |
| cfg_pause_time | input | PT_W | Pause time in slot units, from another clock domain |
| cfg_low_thr | input | 2 | Re-send margin select: 0=4, 1=28, 2=144, 3=256 slots |
| cfg_zq_disable | input | 1 | 1 suppresses the zero-time frame on release |
| fc_request | input | 1 | Flow-control request from the receive FIFO layer |
| slot_tick | input | 1 | One-cycle pulse per elapsed slot time |
| pause_ack | input | 1 | Transmitter accepted the requested frame |
| pause_req | output | 1 | Request to send a PAUSE frame |
| pause_value | output | PT_W | Pause time field for the requested frame |
| back_pressure | output | 1 | Half-duplex back-pressure drive |

## Verification
The bench walks a table of pause times and margin codes. It counts slot ticks one at a time up to the re-send point, so a margin that is off by a single slot, or a compare that is off by one, shows up as a request one tick early or late. Cases where the margin exceeds the pause time catch a subtraction that wraps, which would stall the re-send for thousands of slots.

Directed cases cover the following. A request left unacknowledged must keep its value while the configuration changes underneath it. A release must produce exactly one zero-time frame, or none when suppressed; a wrong polarity would silently swap the two. A disabled or half-duplex link must never emit frames. A frame fired on the edge right after a pause-time write must carry the old value; a design that skips the synchronizer would send the new one.

// File: rtl/pause_fc_pkg.sv
package pause_fc_pkg;

   typedef enum logic [1:0] {
      ST_IDLE    = 2'd0,
      ST_SEND_PT = 2'd1,
      ST_HOLD    = 2'd2,
      ST_SEND_ZQ = 2'd3
   } fc_state_e;

   localparam int MARGIN_W = 9;

   // Re-send margin in slot times selected by the low-threshold code.
   function automatic logic [MARGIN_W-1:0] margin_slots(input logic [1:0] code);
      case (code)
         2'd0:    margin_slots = 9'd4;
         2'd1:    margin_slots = 9'd28;
         2'd2:    margin_slots = 9'd144;
         default: margin_slots = 9'd256;
      endcase
   endfunction

endpackage

// File: rtl/pause_cfg_sync.sv
module pause_cfg_sync #(
   parameter int WIDTH  = 16,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_async,
   output logic [WIDTH-1:0] q_sync
);

   initial begin
      if (WIDTH < 1) $error("pause_cfg_sync: WIDTH must be positive");
      if (STAGES < 0 || STAGES > 4) $error("pause_cfg_sync: STAGES out of range 0..4");
   end

   generate
      if (STAGES == 0) begin : g_bypass
         assign q_sync = d_async;
      end else begin : g_chain
         logic [WIDTH-1:0] stage_q [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
            end else begin
               stage_q[0] <= d_async;
               for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
            end
         end
         assign q_sync = stage_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/pause_slot_timer.sv
module pause_slot_timer
   import pause_fc_pkg::*;
#(
   parameter int PT_W = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic [PT_W-1:0] load_val,
   input  logic            tick,
   input  logic [1:0]      thr_code,
   output logic            at_margin
);

   localparam int PAD_W = PT_W - MARGIN_W;

   initial begin
      if (PT_W < MARGIN_W + 1) $error("pause_slot_timer: PT_W must exceed margin width");
   end

   logic [PT_W-1:0] remain_q;
   logic [PT_W-1:0] margin_ext;

   assign margin_ext = {{PAD_W{1'b0}}, margin_slots(thr_code)};
   // A margin at or above the loaded time is reached immediately (threshold reads as zero).
   assign at_margin  = (remain_q <= margin_ext);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     remain_q <= '0;
      else if (load)                  remain_q <= load_val;
      else if (tick && remain_q != 0) remain_q <= remain_q - 1'b1;
   end

   p_hold_at_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (remain_q == 0 && !load) |=> remain_q == 0);

   p_count_only_on_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !tick) |=> $stable(remain_q));

endmodule

// File: rtl/pause_req_fsm.sv
module pause_req_fsm
   import pause_fc_pkg::*;
#(
   parameter int PT_W = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            fd_active,
   input  logic            fc_req,
   input  logic            zq_dis,
   input  logic [PT_W-1:0] pt_sync,
   input  logic            at_margin,
   input  logic            ack,
   output logic            req,
   output logic [PT_W-1:0] value,
   output logic            timer_load
);

   fc_state_e       state_q, state_d;
   logic [PT_W-1:0] value_q, value_d;

   assign req        = (state_q == ST_SEND_PT) || (state_q == ST_SEND_ZQ);
   assign value      = value_q;
   assign timer_load = (state_q == ST_SEND_PT) && ack;

   always_comb begin
      state_d = state_q;
      value_d = value_q;
      case (state_q)
         ST_IDLE: begin
            if (fd_active && fc_req) begin
               state_d = ST_SEND_PT;
               value_d = pt_sync;
            end
         end
         ST_SEND_PT: if (ack) state_d = ST_HOLD;
         ST_HOLD: begin
            if (!fd_active) begin
               state_d = ST_IDLE;
            end else if (!fc_req) begin
               if (zq_dis) begin
                  state_d = ST_IDLE;
               end else begin
                  state_d = ST_SEND_ZQ;
                  value_d = '0;
               end
            end else if (at_margin) begin
               state_d = ST_SEND_PT;
               value_d = pt_sync;
            end
         end
         ST_SEND_ZQ: if (ack) state_d = ST_IDLE;
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         value_q <= '0;
      end else begin
         state_q <= state_d;
         value_q <= value_d;
      end
   end

   p_req_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (req && !ack) |=> (req && $stable(value)));

   p_rise_needs_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req) |-> $past(fd_active));

   p_zero_after_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_HOLD && fd_active && !fc_req && !zq_dis) |=> (req && value == 0));

   p_no_zero_when_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_HOLD && !fc_req && zq_dis) |=> !req);

endmodule

// File: rtl/pause_tx_ctrl.sv
module pause_tx_ctrl
   import pause_fc_pkg::*;
#(
   parameter int PT_W        = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cfg_enable,
   input  logic            cfg_full_duplex,
   input  logic [PT_W-1:0] cfg_pause_time,
   input  logic [1:0]      cfg_low_thr,
   input  logic            cfg_zq_disable,
   input  logic            fc_request,
   input  logic            slot_tick,
   input  logic            pause_ack,
   output logic            pause_req,
   output logic [PT_W-1:0] pause_value,
   output logic            back_pressure
);

   logic [PT_W-1:0] pt_sync;
   logic            fd_active;
   logic            at_margin;
   logic            timer_load;

   assign fd_active     = cfg_enable && cfg_full_duplex;
   assign back_pressure = cfg_enable && !cfg_full_duplex && fc_request;

   pause_cfg_sync #(.WIDTH(PT_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (cfg_pause_time),
      .q_sync  (pt_sync)
   );

   pause_slot_timer #(.PT_W(PT_W)) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (timer_load),
      .load_val  (pt_sync),
      .tick      (slot_tick),
      .thr_code  (cfg_low_thr),
      .at_margin (at_margin)
   );

   pause_req_fsm #(.PT_W(PT_W)) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .fd_active  (fd_active),
      .fc_req     (fc_request),
      .zq_dis     (cfg_zq_disable),
      .pt_sync    (pt_sync),
      .at_margin  (at_margin),
      .ack        (pause_ack),
      .req        (pause_req),
      .value      (pause_value),
      .timer_load (timer_load)
   );

   p_bp_half_duplex_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
      back_pressure |-> !cfg_full_duplex);

   p_reset_quiet_r1: assert property (@(posedge clk)
      !rst_n |=> (!pause_req || !rst_n));

endmodule

// File: tb/test_pause_tx_ctrl.sv
module test_pause_tx_ctrl;

   localparam int PT_W = 16;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            cfg_enable = 1'b0;
   logic            cfg_full_duplex = 1'b1;
   logic [PT_W-1:0] cfg_pause_time = '0;
   logic [1:0]      cfg_low_thr = '0;
   logic            cfg_zq_disable = 1'b1;
   logic            fc_request = 1'b0;
   logic            slot_tick = 1'b0;
   logic            pause_ack = 1'b0;
   logic            pause_req;
   logic [PT_W-1:0] pause_value;
   logic            back_pressure;

   int n_checks = 0;
   int n_fail   = 0;
   int cycles   = 0;

   always #2 clk = ~clk;   // 250 MHz

   pause_tx_ctrl #(.PT_W(PT_W), .SYNC_STAGES(2)) i_pause_tx_ctrl (
      .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_full_duplex(cfg_full_duplex),
      .cfg_pause_time(cfg_pause_time), .cfg_low_thr(cfg_low_thr), .cfg_zq_disable(cfg_zq_disable),
      .fc_request(fc_request), .slot_tick(slot_tick), .pause_ack(pause_ack),
      .pause_req(pause_req), .pause_value(pause_value), .back_pressure(back_pressure)
   );

   // Vector table: pause time, margin code, ticks expected before re-send.
   localparam int NV = 6;
   localparam int V_PT  [NV] = '{256, 256, 300, 300, 100, 256};
   localparam int V_THR [NV] = '{1,   0,   2,   3,   2,   3  };
   localparam int V_EXP [NV] = '{228, 252, 156, 44,  0,   0  };

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   endtask

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic do_ack();
      pause_ack = 1'b1;
      @(negedge clk);
      pause_ack = 1'b0;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         slot_tick = 1'b1;
         @(negedge clk);
         slot_tick = 1'b0;
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
         finish_run();
      end
   end

   initial begin
      // R1 reset state
      cyc(3);
      check("R1 req in reset", pause_req, 0);
      check("R1 value in reset", pause_value, 0);
      rst_n = 1'b1;
      cyc(1);
      check("R1 req after reset", pause_req, 0);
      check("R1 bp after reset", back_pressure, 0);

      // Table walk: R2 first frame, R4/R5 re-send point, R7 silent release, R11 sync
      cfg_enable = 1'b1;
      cfg_full_duplex = 1'b1;
      cfg_zq_disable = 1'b1;
      for (int v = 0; v < NV; v++) begin
         cfg_pause_time = V_PT[v][PT_W-1:0];
         cfg_low_thr = V_THR[v][1:0];
         cyc(4);
         fc_request = 1'b1;
         cyc(1);
         check("R2 req raised", pause_req, 1);
         check("R11 R2 value synced", pause_value, V_PT[v]);
         do_ack();
         if (V_EXP[v] > 0) begin
            ticks(V_EXP[v] - 1);
            cyc(2);
            check("R4 no early re-send", pause_req, 0);
            ticks(1);
            cyc(1);
            check("R4 re-send at margin", pause_req, 1);
         end else begin
            cyc(1);
            check("R5 immediate re-send", pause_req, 1);
         end
         check("R4 re-send value", pause_value, V_PT[v]);
         do_ack();
         fc_request = 1'b0;
         cyc(3);
         check("R7 no zero frame", pause_req, 0);
      end

      // R10: no ticks, no re-send
      cfg_pause_time = 16'd256;
      cfg_low_thr = 2'd0;
      cyc(4);
      fc_request = 1'b1;
      cyc(1);
      do_ack();
      cyc(60);
      check("R10 no re-send without ticks", pause_req, 0);

      // R6: release sends a zero-time frame
      cfg_zq_disable = 1'b0;
      fc_request = 1'b0;
      cyc(1);
      check("R6 zero frame requested", pause_req, 1);
      check("R6 zero frame value", pause_value, 0);

      // R3: held without ack while configuration moves
      cfg_pause_time = 16'd999;
      cyc(6);
      check("R3 req held", pause_req, 1);
      check("R3 value held", pause_value, 0);
      do_ack();
      cyc(1);
      check("R6 idle after zero frame", pause_req, 0);

      // R11: frame fired on the edge right after a write carries the old value
      fc_request = 1'b1;
      cfg_pause_time = 16'd77;
      cyc(1);
      check("R11 old value on first edge", pause_value, 999);
      do_ack();
      fc_request = 1'b0;
      cyc(1);
      do_ack();
      cyc(2);

      // R8: disabled in full duplex
      cfg_enable = 1'b0;
      fc_request = 1'b1;
      cyc(10);
      check("R8 no req when disabled", pause_req, 0);
      check("R9 no bp in full duplex", back_pressure, 0);
      fc_request = 1'b0;
      cyc(2);

      // R9: half-duplex back-pressure
      cfg_enable = 1'b1;
      cfg_full_duplex = 1'b0;
      cyc(1);
      fc_request = 1'b1;
      #1;
      check("R9 bp follows request", back_pressure, 1);
      cyc(5);
      check("R9 no pause frame in half duplex", pause_req, 0);
      fc_request = 1'b0;
      #1;
      check("R9 bp drops with request", back_pressure, 0);
      cfg_enable = 1'b0;
      fc_request = 1'b1;
      #1;
      check("R9 bp off when disabled", back_pressure, 0);
      fc_request = 1'b0;
      cyc(2);

      finish_run();
   end

endmodule